// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block runs the source side of DisplayPort link training as a single hardware sequence. A one-cycle `start` pulse latches the lane count, link-rate code and sink capability flags. The block then steps through four stages. It prepares the sink. It runs a clock-recovery loop, then a channel-equalization loop. It always ends with a finish step, whatever happened in the loops. When the finish step completes, it raises `done` for one cycle. At that point `pass` gives the result and `driveSet` holds the last drive byte that was applied.

All traffic goes out through one abstract command port. Each command is either a sink register write, a sink status read, a source command or a source drive-level update. A command stays presented until the transport answers with `cmdDone`. For a status read, the per-lane OK flags, the per-lane adjust requests and an error flag are sampled in the same cycle as `cmdDone`. Wait intervals are counted in pulses of a microsecond tick `usTick`. The settle interval is a parameter. The per-phase polling waits are inputs.

The adjust requests arrive as 2-bit fields per lane. The block merges them into one drive byte: voltage in bits 1:0, a max-swing flag in bit 2, pre-emphasis in bits 4:3 and a max-pre-emphasis flag in bit 5. The same byte is broadcast to every active lane.

Top module: `dp_link_trainer`

## Requirements
- R1: After reset, `busy`, `cmdValid`, `done`, `pass` and `driveSet` are all zero.
- R2: Sink preparation issues these commands in this order. Each sink write gives the register selector, then the value:
  - selector 0 = 1 (power on);
  - selector 1 = 0x10 if downspread is supported, else 0;
  - selector 2 = lane count, with bit 7 set if enhanced framing is supported;
  - selector 3 = rate code;
  - source command 1 (start training);
  - selector 4 = 0 (pattern off).
- R3: Clock recovery starts with source command 2 and then selector 4 = 1. It then clears the drive byte and applies it. The first status read is issued only after at least the settle count (default 400 ticks) plus the clock-recovery wait.
- R4: Clock recovery passes when the clock-recovery OK flag is set on every active lane. OK flags of lanes at or above the lane count are ignored.
- R5: A failed clock-recovery check aborts to the finish step if the current drive byte already has the max-swing flag (bit 2) set.
- R6: After a failed clock-recovery check, the lane-0 voltage is compared with the value saved at the previous check. If it is the same, a try counter increments, and the phase aborts when the counter reaches 5. If it differs, the counter is cleared.
- R7: An adjust takes the largest voltage request and the largest pre-emphasis request over the active lanes. It sets the matching flag when a value is 3. A drive update is a source drive command with the byte, followed by sink writes to selectors 5 up to 4+lane count, all carrying the same byte.
- R8: Channel equalization uses source command 4 and pattern value 3 when TPS3 is supported. Otherwise it uses source command 3 and pattern value 2.
- R9: Channel equalization passes when the EQ OK flag is set on every active lane. After a failed check it aborts once six adjusts have been done, which means the seventh failed read.
- R10: A status read completing with `cmdErr` high aborts the current phase as a failure.
- R11: The finish step always runs. It waits at least the settle count, writes selector 4 = 0, then issues source command 5. It then pulses `done` for one cycle, with `pass` high only if equalization passed.
- R12: While `cmdValid` is high and `cmdDone` is low, the command fields stay unchanged.
- R13: Each status read after a drive update, and each equalization read, waits at least the phase's wait input, counted in `usTick` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training run (ignored while busy) |
| laneCount | input | 3 | Active lanes: 1, 2 or 4 |
| rateCode | input | 8 | Link-rate code written to the sink |
| capTps3 | input | 1 | Sink supports training pattern 3 |
| capEnhanced | input | 1 | Sink supports enhanced framing |
| capSpread | input | 1 | Sink supports downspread |
| usTick | input | 1 | One-cycle microsecond tick |
| crWaitUs | input | 8 | Ticks to wait before each clock-recovery read |
| eqWaitUs | input | 8 | Ticks to wait before each equalization read |
| cmdValid | output | 1 | Command presented |
| cmdKind | output | 2 | 0 sink write, 1 status read, 2 source command, 3 source drive |
| cmdAddr | output | 4 | Sink register selector |
| cmdData | output | 8 | Write value, source command code or drive byte |
| cmdDone | input | 1 | Command completed |
| cmdErr | input | 1 | Status read failed (sampled with cmdDone) |
| stCrOk | input | 4 | Per-lane clock-recovery OK |
| stEqOk | input | 4 | Per-lane equalization OK |
| stVolt | input | 8 | Per-lane voltage request, 2 bits per lane |
| stPre | input | 8 | Per-lane pre-emphasis request, 2 bits per lane |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Training result |
| driveSet | output | 8 | Current drive byte |

## Verification
Command outputs are combinational from the state, so the next command appears in the cycle after the previous `cmdDone`. The evaluation of a status read takes one more cycle before the next drive command shows. The bench therefore never predicts cycle positions for commands. It logs each command at the moment it answers it and compares the ordered log with a reference sequence.

Waits are checked as tick counts between handshakes. Each count must lie between the required value and that value plus four. The margin covers the load cycle, the exit cycle and the transport's answer delay. `pass` and `driveSet` are read in the cycle where `done` is seen, and `done` is checked low one cycle later.

// File: rtl/dplt_pkg.sv
package dplt_pkg;
  localparam logic [1:0] K_SINK_WR   = 2'd0;
  localparam logic [1:0] K_STATUS    = 2'd1;
  localparam logic [1:0] K_SRC_CMD   = 2'd2;
  localparam logic [1:0] K_SRC_DRIVE = 2'd3;

  localparam logic [3:0] SEL_POWER   = 4'd0;
  localparam logic [3:0] SEL_SPREAD  = 4'd1;
  localparam logic [3:0] SEL_LANES   = 4'd2;
  localparam logic [3:0] SEL_RATE    = 4'd3;
  localparam logic [3:0] SEL_PATTERN = 4'd4;
  localparam logic [3:0] SEL_LANESET = 4'd5;

  localparam logic [7:0] SRC_START = 8'd1;
  localparam logic [7:0] SRC_PAT1  = 8'd2;
  localparam logic [7:0] SRC_PAT2  = 8'd3;
  localparam logic [7:0] SRC_PAT3  = 8'd4;
  localparam logic [7:0] SRC_DONE  = 8'd5;

  localparam logic [7:0] PWR_ON      = 8'h01;
  localparam logic [7:0] SPREAD_HALF = 8'h10;

  localparam logic [1:0] W_SETTLE = 2'd0;
  localparam logic [1:0] W_CR     = 2'd1;
  localparam logic [1:0] W_EQ     = 2'd2;

  typedef enum logic [1:0] {PH_CR, PH_EQ, PH_FIN} phase_t;

  typedef struct packed {
    logic       clrDrive;
    logic       applyAdj;
    logic       latchStat;
    logic       loadWait;
    logic [1:0] waitSel;
    logic       savePrev;
    logic       clrPrev;
    logic       laneClr;
    logic       laneInc;
  } lt_strobe_t;
endpackage

// File: rtl/dplt_datapath.sv
module dplt_datapath
  import dplt_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DLY_W     = 8,
  parameter int SETTLE_US = 400,
  parameter int WAIT_W    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lt_strobe_t              stb,
  input  logic [2:0]              cfgLanes,
  input  logic                    usTick,
  input  logic [DLY_W-1:0]        crWaitUs,
  input  logic [DLY_W-1:0]        eqWaitUs,
  input  logic [LANES-1:0]        stCrOk,
  input  logic [LANES-1:0]        stEqOk,
  input  logic [2*LANES-1:0]      stVolt,
  input  logic [2*LANES-1:0]      stPre,
  output logic [7:0]              trainSet,
  output logic [$clog2(LANES)-1:0] laneIdx,
  output logic                    lastLane,
  output logic                    waitDone,
  output logic                    allCrOk,
  output logic                    allEqOk,
  output logic                    allMax,
  output logic                    sameVolt
);
  localparam int LIDX_W = $clog2(LANES);

  logic [LANES-1:0]     act;
  logic [LANES-1:0]     crOkQ, eqOkQ;
  logic [2*LANES-1:0]   voltQ, preQ;
  logic [1:0]           prevVolt;
  logic                 prevValid;
  logic [WAIT_W-1:0]    waitCnt, waitLen;
  logic [1:0]           vMax, pMax;
  logic [7:0]           adjByte;

  for (genvar i = 0; i < LANES; i++) begin : g_act
    assign act[i] = (cfgLanes > 3'(i));
  end

  always_comb begin
    vMax = 2'd0;
    pMax = 2'd0;
    for (int i = 0; i < LANES; i++) begin
      if (act[i] && voltQ[2*i +: 2] > vMax) vMax = voltQ[2*i +: 2];
      if (act[i] && preQ[2*i +: 2] > pMax)  pMax = preQ[2*i +: 2];
    end
    adjByte = {2'b00, (pMax == 2'd3), pMax, (vMax == 2'd3), vMax};
  end

  always_comb begin
    case (stb.waitSel)
      W_CR:    waitLen = WAIT_W'(crWaitUs);
      W_EQ:    waitLen = WAIT_W'(eqWaitUs);
      default: waitLen = WAIT_W'(SETTLE_US);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trainSet  <= '0;
      crOkQ     <= '0;
      eqOkQ     <= '0;
      voltQ     <= '0;
      preQ      <= '0;
      prevVolt  <= '0;
      prevValid <= 1'b0;
      waitCnt   <= '0;
      laneIdx   <= '0;
    end else begin
      if (stb.clrDrive)      trainSet <= '0;
      else if (stb.applyAdj) trainSet <= adjByte;
      if (stb.latchStat) begin
        crOkQ <= stCrOk;
        eqOkQ <= stEqOk;
        voltQ <= stVolt;
        preQ  <= stPre;
      end
      if (stb.clrPrev) prevValid <= 1'b0;
      else if (stb.savePrev) begin
        prevVolt  <= trainSet[1:0];
        prevValid <= 1'b1;
      end
      if (stb.loadWait)                    waitCnt <= waitLen;
      else if (usTick && waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
      if (stb.laneClr)      laneIdx <= '0;
      else if (stb.laneInc) laneIdx <= laneIdx + 1'b1;
    end
  end

  assign waitDone = (waitCnt == '0);
  assign lastLane = ((3'(laneIdx) + 3'd1) == cfgLanes);
  assign allCrOk  = &(crOkQ | ~act);
  assign allEqOk  = &(eqOkQ | ~act);
  assign allMax   = trainSet[2];
  assign sameVolt = prevValid && (prevVolt == trainSet[1:0]);

  AST_ADJ_COVERS_LANE0: assert property (@(posedge clk) disable iff (!rstN)
    (stb.applyAdj && !stb.clrDrive) |=> (trainSet[1:0] >= $past(voltQ[1:0]))); // R7
  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (usTick && !stb.loadWait && waitCnt != '0) |=> (waitCnt == $past(waitCnt) - 1'b1)); // R13
  localparam int UNUSED_LIDX = LIDX_W;
endmodule

// File: rtl/dplt_control.sv
module dplt_control
  import dplt_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [2:0]               laneCount,
  input  logic [7:0]               rateCode,
  input  logic                     capTps3,
  input  logic                     capEnhanced,
  input  logic                     capSpread,
  input  logic                     cmdDone,
  input  logic                     cmdErr,
  input  logic [7:0]               trainSet,
  input  logic [$clog2(LANES)-1:0] laneIdx,
  input  logic                     lastLane,
  input  logic                     waitDone,
  input  logic                     allCrOk,
  input  logic                     allEqOk,
  input  logic                     allMax,
  input  logic                     sameVolt,
  output lt_strobe_t               stb,
  output logic [2:0]               cfgLanes,
  output logic                     cmdValid,
  output logic [1:0]               cmdKind,
  output logic [3:0]               cmdAddr,
  output logic [7:0]               cmdData,
  output logic                     busy,
  output logic                     done,
  output logic                     pass
);
  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_SPREAD, S_LANES, S_RATE, S_SRCSTART, S_PATOFF,
    S_SRCPAT, S_SINKPAT, S_DRV_SRC, S_DRV_LANE, S_SETTLE, S_WAIT,
    S_STAT, S_EVAL, S_FIN_PAT, S_FIN_CPL, S_DONE
  } state_t;

  state_t     state, stateNxt;
  phase_t     phase, phaseNxt;
  logic [2:0] tries, triesNxt;
  logic       passQ, passNxt, firstQ, firstNxt, cfgLoad;
  logic [7:0] rateQ;
  logic       tps3Q, enhQ, spreadQ;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    phaseNxt = phase;
    triesNxt = tries;
    passNxt  = passQ;
    firstNxt = firstQ;
    cfgLoad  = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        cfgLoad  = 1'b1;
        passNxt  = 1'b0;
        stateNxt = S_PWR;
      end
      S_PWR:      if (cmdDone) stateNxt = S_SPREAD;
      S_SPREAD:   if (cmdDone) stateNxt = S_LANES;
      S_LANES:    if (cmdDone) stateNxt = S_RATE;
      S_RATE:     if (cmdDone) stateNxt = S_SRCSTART;
      S_SRCSTART: if (cmdDone) stateNxt = S_PATOFF;
      S_PATOFF:   if (cmdDone) begin
        phaseNxt = PH_CR;
        stateNxt = S_SRCPAT;
      end
      S_SRCPAT:   if (cmdDone) stateNxt = S_SINKPAT;
      S_SINKPAT:  if (cmdDone) begin
        triesNxt = '0;
        if (phase == PH_CR) begin
          stb.clrDrive = 1'b1;
          stb.clrPrev  = 1'b1;
          firstNxt     = 1'b1;
          stateNxt     = S_DRV_SRC;
        end else begin
          stb.loadWait = 1'b1;
          stb.waitSel  = W_EQ;
          stateNxt     = S_WAIT;
        end
      end
      S_DRV_SRC: if (cmdDone) begin
        stb.laneClr = 1'b1;
        stateNxt    = S_DRV_LANE;
      end
      S_DRV_LANE: if (cmdDone) begin
        if (lastLane) begin
          stb.loadWait = 1'b1;
          if (firstQ) begin
            firstNxt    = 1'b0;
            stb.waitSel = W_SETTLE;
            stateNxt    = S_SETTLE;
          end else begin
            stb.waitSel = (phase == PH_EQ) ? W_EQ : W_CR;
            stateNxt    = S_WAIT;
          end
        end else begin
          stb.laneInc = 1'b1;
        end
      end
      S_SETTLE: if (waitDone) begin
        if (phase == PH_FIN) stateNxt = S_FIN_PAT;
        else begin
          stb.loadWait = 1'b1;
          stb.waitSel  = W_CR;
          stateNxt     = S_WAIT;
        end
      end
      S_WAIT: if (waitDone) stateNxt = S_STAT;
      S_STAT: if (cmdDone) begin
        stb.latchStat = 1'b1;
        if (cmdErr) begin
          phaseNxt     = PH_FIN;
          passNxt      = 1'b0;
          stb.loadWait = 1'b1;
          stb.waitSel  = W_SETTLE;
          stateNxt     = S_SETTLE;
        end else begin
          stateNxt = S_EVAL;
        end
      end
      S_EVAL: begin
        if (phase == PH_CR) begin
          if (allCrOk) begin
            phaseNxt = PH_EQ;
            stateNxt = S_SRCPAT;
          end else if (allMax || (sameVolt && tries == 3'd4)) begin
            phaseNxt     = PH_FIN;
            passNxt      = 1'b0;
            stb.loadWait = 1'b1;
            stb.waitSel  = W_SETTLE;
            stateNxt     = S_SETTLE;
          end else begin
            triesNxt     = sameVolt ? tries + 3'd1 : 3'd0;
            stb.savePrev = 1'b1;
            stb.applyAdj = 1'b1;
            stateNxt     = S_DRV_SRC;
          end
        end else begin
          if (allEqOk || tries > 3'd5) begin
            phaseNxt     = PH_FIN;
            passNxt      = allEqOk;
            stb.loadWait = 1'b1;
            stb.waitSel  = W_SETTLE;
            stateNxt     = S_SETTLE;
          end else begin
            triesNxt     = tries + 3'd1;
            stb.applyAdj = 1'b1;
            stateNxt     = S_DRV_SRC;
          end
        end
      end
      S_FIN_PAT: if (cmdDone) stateNxt = S_FIN_CPL;
      S_FIN_CPL: if (cmdDone) stateNxt = S_DONE;
      S_DONE:    stateNxt = S_IDLE;
      default:   stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phase    <= PH_CR;
      tries    <= '0;
      passQ    <= 1'b0;
      firstQ   <= 1'b0;
      cfgLanes <= 3'd1;
      rateQ    <= '0;
      tps3Q    <= 1'b0;
      enhQ     <= 1'b0;
      spreadQ  <= 1'b0;
    end else begin
      state  <= stateNxt;
      phase  <= phaseNxt;
      tries  <= triesNxt;
      passQ  <= passNxt;
      firstQ <= firstNxt;
      if (cfgLoad) begin
        cfgLanes <= laneCount;
        rateQ    <= rateCode;
        tps3Q    <= capTps3;
        enhQ     <= capEnhanced;
        spreadQ  <= capSpread;
      end
    end
  end

  always_comb begin
    cmdValid = 1'b1;
    cmdKind  = K_SINK_WR;
    cmdAddr  = '0;
    cmdData  = '0;
    case (state)
      S_PWR:      begin cmdAddr = SEL_POWER;   cmdData = PWR_ON; end
      S_SPREAD:   begin cmdAddr = SEL_SPREAD;  cmdData = spreadQ ? SPREAD_HALF : 8'h00; end
      S_LANES:    begin cmdAddr = SEL_LANES;   cmdData = {enhQ, 4'b0000, cfgLanes}; end
      S_RATE:     begin cmdAddr = SEL_RATE;    cmdData = rateQ; end
      S_SRCSTART: begin cmdKind = K_SRC_CMD;   cmdData = SRC_START; end
      S_PATOFF,
      S_FIN_PAT:  begin cmdAddr = SEL_PATTERN; cmdData = 8'h00; end
      S_SRCPAT: begin
        cmdKind = K_SRC_CMD;
        cmdData = (phase == PH_CR) ? SRC_PAT1 : (tps3Q ? SRC_PAT3 : SRC_PAT2);
      end
      S_SINKPAT: begin
        cmdAddr = SEL_PATTERN;
        cmdData = (phase == PH_CR) ? 8'd1 : (tps3Q ? 8'd3 : 8'd2);
      end
      S_DRV_SRC:  begin cmdKind = K_SRC_DRIVE; cmdData = trainSet; end
      S_DRV_LANE: begin cmdAddr = SEL_LANESET + 4'(laneIdx); cmdData = trainSet; end
      S_STAT:     cmdKind = K_STATUS;
      S_FIN_CPL:  begin cmdKind = K_SRC_CMD;   cmdData = SRC_DONE; end
      default:    cmdValid = 1'b0;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
  assign pass = passQ;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable({cmdKind, cmdAddr, cmdData}))); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_DONE_AFTER_CPL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(cmdDone)); // R11
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STAT && cmdDone && cmdErr) |=> (state == S_SETTLE && phase == PH_FIN && !pass)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid); // R1
endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
  import dplt_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DLY_W     = 8,
  parameter int SETTLE_US = 400,
  parameter int WAIT_W    = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         laneCount,
  input  logic [7:0]         rateCode,
  input  logic               capTps3,
  input  logic               capEnhanced,
  input  logic               capSpread,
  input  logic               usTick,
  input  logic [DLY_W-1:0]   crWaitUs,
  input  logic [DLY_W-1:0]   eqWaitUs,
  output logic               cmdValid,
  output logic [1:0]         cmdKind,
  output logic [3:0]         cmdAddr,
  output logic [7:0]         cmdData,
  input  logic               cmdDone,
  input  logic               cmdErr,
  input  logic [LANES-1:0]   stCrOk,
  input  logic [LANES-1:0]   stEqOk,
  input  logic [2*LANES-1:0] stVolt,
  input  logic [2*LANES-1:0] stPre,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic [7:0]         driveSet
);
  localparam int LIDX_W = $clog2(LANES);

  lt_strobe_t        stb;
  logic [2:0]        cfgLanes;
  logic [LIDX_W-1:0] laneIdx;
  logic              lastLane, waitDone, allCrOk, allEqOk, allMax, sameVolt;

  dplt_control #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .laneCount(laneCount),
    .rateCode(rateCode), .capTps3(capTps3), .capEnhanced(capEnhanced),
    .capSpread(capSpread), .cmdDone(cmdDone), .cmdErr(cmdErr),
    .trainSet(driveSet), .laneIdx(laneIdx), .lastLane(lastLane),
    .waitDone(waitDone), .allCrOk(allCrOk), .allEqOk(allEqOk),
    .allMax(allMax), .sameVolt(sameVolt), .stb(stb), .cfgLanes(cfgLanes),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .busy(busy), .done(done), .pass(pass)
  );

  dplt_datapath #(
    .LANES(LANES), .DLY_W(DLY_W), .SETTLE_US(SETTLE_US), .WAIT_W(WAIT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgLanes(cfgLanes), .usTick(usTick),
    .crWaitUs(crWaitUs), .eqWaitUs(eqWaitUs), .stCrOk(stCrOk),
    .stEqOk(stEqOk), .stVolt(stVolt), .stPre(stPre), .trainSet(driveSet),
    .laneIdx(laneIdx), .lastLane(lastLane), .waitDone(waitDone),
    .allCrOk(allCrOk), .allEqOk(allEqOk), .allMax(allMax), .sameVolt(sameVolt)
  );
endmodule

// File: tb/dp_link_trainer_tb.sv
module dp_link_trainer_tb;
  localparam int NR = 32;
  localparam int NE = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] laneCount = 3'd1;
  logic [7:0] rateCode = 8'h0a;
  logic capTps3 = 1'b0, capEnhanced = 1'b0, capSpread = 1'b0;
  logic usTick = 1'b0;
  logic [7:0] crWaitUs = 8'd0, eqWaitUs = 8'd0;
  logic cmdValid, busy, done, pass;
  logic [1:0] cmdKind;
  logic [3:0] cmdAddr;
  logic [7:0] cmdData, driveSet;
  logic cmdDone = 1'b0, cmdErr = 1'b0;
  logic [3:0] stCrOk = '0, stEqOk = '0;
  logic [7:0] stVolt = '0, stPre = '0;

  dp_link_trainer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .laneCount(laneCount),
    .rateCode(rateCode), .capTps3(capTps3), .capEnhanced(capEnhanced),
    .capSpread(capSpread), .usTick(usTick), .crWaitUs(crWaitUs),
    .eqWaitUs(eqWaitUs), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdDone(cmdDone), .cmdErr(cmdErr),
    .stCrOk(stCrOk), .stEqOk(stEqOk), .stVolt(stVolt), .stPre(stPre),
    .busy(busy), .done(done), .pass(pass), .driveSet(driveSet)
  );

  always #4 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit hung = 0;

  logic [3:0] rCr[NR], rEq[NR];
  logic [7:0] rVolt[NR], rPre[NR];
  bit         rErr[NR];
  int respIdx = 0;

  logic [1:0] expKind[NE];
  logic [3:0] expAddr[NE];
  logic [7:0] expData[NE];
  int         expTick[NE];
  string      expReq[NE];
  int  expN;
  bit  expPass;
  logic [7:0] expDrive;

  logic [1:0] actKind[NE];
  logic [3:0] actAddr[NE];
  logic [7:0] actData[NE];
  int         actTick[NE];
  int  actN = 0;
  int  tickSince = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void getResp(int i, output logic [3:0] cr, output logic [3:0] eq,
                                  output logic [7:0] v, output logic [7:0] p, output bit e);
    if (i < NR) begin
      cr = rCr[i]; eq = rEq[i]; v = rVolt[i]; p = rPre[i]; e = rErr[i];
    end else begin
      cr = 4'hF; eq = 4'hF; v = 8'h00; p = 8'h00; e = 1'b0;
    end
  endfunction

  function automatic logic [7:0] refAdjust(int lc, logic [7:0] v, logic [7:0] p);
    logic [1:0] vm = 0, pm = 0;
    for (int i = 0; i < lc; i++) begin
      if (v[2*i +: 2] > vm) vm = v[2*i +: 2];
      if (p[2*i +: 2] > pm) pm = p[2*i +: 2];
    end
    return {2'b00, pm == 2'd3, pm, vm == 2'd3, vm};
  endfunction

  function automatic void push(logic [1:0] k, logic [3:0] a, logic [7:0] d, int t, string r);
    if (expN < NE) begin
      expKind[expN] = k; expAddr[expN] = a; expData[expN] = d;
      expTick[expN] = t; expReq[expN] = r;
    end
    expN++;
  endfunction

  function automatic void pushDrive(int lc, logic [7:0] ts);
    push(2'd3, 4'd0, ts, -1, "R7");
    for (int i = 0; i < lc; i++) push(2'd0, 4'(5 + i), ts, -1, "R7");
  endfunction

  // Reference sequence built from the requirements
  function automatic void buildModel(int lc);
    logic [3:0] cr, eq, mask;
    logic [7:0] v, p, ts;
    bit e, crPass = 0, prevValid = 0, fin = 0;
    logic [1:0] prevVolt = 0;
    int tries = 0, r = 0, nextTick;
    mask = (lc == 1) ? 4'h1 : (lc == 2) ? 4'h3 : 4'hF;
    expN = 0; expPass = 0;
    push(2'd0, 4'd0, 8'h01, -1, "R2");
    push(2'd0, 4'd1, capSpread ? 8'h10 : 8'h00, -1, "R2");
    push(2'd0, 4'd2, {capEnhanced, 4'b0, 3'(lc)}, -1, "R2");
    push(2'd0, 4'd3, rateCode, -1, "R2");
    push(2'd2, 4'd0, 8'd1, -1, "R2");
    push(2'd0, 4'd4, 8'd0, -1, "R2");
    push(2'd2, 4'd0, 8'd2, -1, "R3");
    push(2'd0, 4'd4, 8'd1, -1, "R3");
    ts = 8'h00;
    pushDrive(lc, ts);
    nextTick = 400 + int'(crWaitUs);
    while (!fin) begin
      push(2'd1, 4'd0, 8'd0, nextTick, "R13");
      getResp(r, cr, eq, v, p, e); r++;
      if (e) fin = 1;                                   // R10
      else if ((cr & mask) == mask) begin crPass = 1; fin = 1; end   // R4
      else if (ts[2]) fin = 1;                          // R5
      else begin
        if (prevValid && prevVolt == ts[1:0]) begin     // R6
          tries++;
          if (tries == 5) fin = 1;
        end else tries = 0;
        if (!fin) begin
          prevVolt = ts[1:0]; prevValid = 1;
          ts = refAdjust(lc, v, p);
          pushDrive(lc, ts);
          nextTick = int'(crWaitUs);
        end
      end
    end
    if (crPass) begin
      push(2'd2, 4'd0, capTps3 ? 8'd4 : 8'd3, -1, "R8");
      push(2'd0, 4'd4, capTps3 ? 8'd3 : 8'd2, -1, "R8");
      tries = 0; fin = 0;
      while (!fin) begin
        push(2'd1, 4'd0, 8'd0, int'(eqWaitUs), "R13");
        getResp(r, cr, eq, v, p, e); r++;
        if (e) fin = 1;
        else if ((eq & mask) == mask) begin expPass = 1; fin = 1; end
        else if (tries > 5) fin = 1;                     // R9
        else begin
          ts = refAdjust(lc, v, p);
          pushDrive(lc, ts);
          tries++;
        end
      end
    end
    push(2'd0, 4'd4, 8'd0, 400, "R11");
    push(2'd2, 4'd0, 8'd5, -1, "R11");
    expDrive = ts;
  endfunction

  // Transport responder, tick source and command logger
  initial begin
    int dly = 0;
    bit pend = 0;
    logic [13:0] held = '0;
    logic [3:0] cr, eq; logic [7:0] v, p; bit e;
    forever begin
      @(negedge clk);
      if (cmdDone) begin
        cmdDone = 1'b0; cmdErr = 1'b0;
      end else if (cmdValid && rstN) begin
        if (!pend) begin pend = 1; held = {cmdKind, cmdAddr, cmdData}; end
        if (dly == 0) begin
          check(held == {cmdKind, cmdAddr, cmdData}, "R12", "command held", int'({cmdKind, cmdAddr, cmdData}), int'(held));
          if (actN < NE) begin
            actKind[actN] = cmdKind; actAddr[actN] = cmdAddr;
            actData[actN] = cmdData; actTick[actN] = tickSince;
          end
          actN++;
          tickSince = 0;
          if (cmdKind == 2'd1) begin
            getResp(respIdx, cr, eq, v, p, e);
            respIdx++;
            stCrOk = cr; stEqOk = eq; stVolt = v; stPre = p; cmdErr = e;
          end
          cmdDone = 1'b1;
          pend = 0;
          dly = $urandom % 3;
        end else dly--;
      end
      usTick = ~usTick;
      if (usTick) tickSince++;
    end
  end

  task automatic runOne(string name, int lc);
    int cyc = 0;
    buildModel(lc);
    actN = 0; respIdx = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
    if (!done) begin
      check(0, "R11", {name, " watchdog"}, cyc, 0);
      hung = 1;
      return;
    end
    check(pass == expPass, "R11", {name, " pass"}, int'(pass), int'(expPass));
    check(driveSet == expDrive, "R7", {name, " driveSet"}, int'(driveSet), int'(expDrive));
    @(negedge clk);
    check(!done, "R11", {name, " done width"}, int'(done), 0);
    check(actN == expN, "R2", {name, " command count"}, actN, expN);
    for (int i = 0; i < expN && i < actN && i < NE; i++) begin
      check({actKind[i], actAddr[i], actData[i]} == {expKind[i], expAddr[i], expData[i]},
            expReq[i], $sformatf("%s cmd %0d", name, i),
            int'({actKind[i], actAddr[i], actData[i]}), int'({expKind[i], expAddr[i], expData[i]}));
      if (expTick[i] >= 0)
        check(actTick[i] >= expTick[i] && actTick[i] <= expTick[i] + 4,
              (expTick[i] >= 400) ? ((i + 2 >= expN) ? "R11" : "R3") : "R13",
              $sformatf("%s ticks before cmd %0d", name, i), actTick[i], expTick[i]);
    end
  endtask

  task automatic clearResp();
    for (int i = 0; i < NR; i++) begin
      rCr[i] = 4'h0; rEq[i] = 4'h0; rVolt[i] = 8'h00; rPre[i] = 8'h00; rErr[i] = 0;
    end
  endtask

  initial begin
    int lcs[3] = '{1, 2, 4};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !cmdValid && !done && !pass && driveSet == 8'h00, "R1", "reset state",
          int'({busy, cmdValid, done, pass, driveSet}), 0);

    // R4: immediate pass on four lanes
    clearResp(); rCr[0] = 4'hF; rEq[0] = 4'hF;
    laneCount = 3'd4; capSpread = 1; capEnhanced = 1; capTps3 = 0; crWaitUs = 3; eqWaitUs = 5;
    runOne("direct_pass", 4);

    // R6: same voltage requested forever
    if (!hung) begin
      clearResp();
      for (int i = 0; i < NR; i++) rVolt[i] = 8'h55;
      laneCount = 3'd4; capSpread = 0; capEnhanced = 0;
      runOne("repeat_volt", 4);
    end

    // R5: max swing on lane 1
    if (!hung) begin
      clearResp(); rVolt[0] = 8'h0C;
      laneCount = 3'd2;
      runOne("max_swing", 2);
    end

    // R10: status error during equalization
    if (!hung) begin
      clearResp(); rCr[0] = 4'hF; rErr[1] = 1;
      laneCount = 3'd1;
      runOne("status_err", 1);
    end

    // R9 and R8: equalization exhausts tries with pattern 3
    if (!hung) begin
      clearResp(); rCr[0] = 4'hF;
      for (int i = 1; i < NR; i++) begin rVolt[i] = 8'h41; rPre[i] = 8'h0B; end
      laneCount = 3'd4; capTps3 = 1;
      runOne("eq_exhaust", 4);
    end

    // R4 and R7: lanes beyond the count are ignored
    if (!hung) begin
      clearResp(); rCr[0] = 4'hE; rVolt[0] = 8'hC1; rPre[0] = 8'hF0;
      rCr[1] = 4'h1; rEq[1] = 4'h1;
      laneCount = 3'd1; capTps3 = 0;
      runOne("inactive_lanes", 1);
    end

    // Constrained random runs
    for (int run = 0; run < 18 && !hung; run++) begin
      int lc = lcs[$urandom % 3];
      for (int i = 0; i < NR; i++) begin
        rCr[i]   = ($urandom % 4 == 0) ? 4'hF : 4'($urandom);
        rEq[i]   = ($urandom % 5 == 0) ? 4'hF : 4'($urandom);
        rVolt[i] = 8'($urandom);
        rPre[i]  = 8'($urandom);
        rErr[i]  = ($urandom % 40 == 0);
      end
      laneCount = 3'(lc); rateCode = 8'($urandom);
      capTps3 = 1'($urandom); capEnhanced = 1'($urandom); capSpread = 1'($urandom);
      crWaitUs = 8'($urandom % 8); eqWaitUs = 8'($urandom % 8);
      runOne($sformatf("rand%0d", run), lc);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule